// File: doc/BRIEF.md
# Transmit Descriptor Submission Engine

The engine takes transmit requests from a host, one 32-bit write per request. Each request word points at a descriptor in a shared memory buffer and gives the rounded size of that descriptor. Requests wait in an internal queue. The engine serves them one at a time. For each request it reads the descriptor header and then the payload words through a single memory port, and sends the payload out as a byte stream with the selected port mask beside it. It then writes a completion flag into the descriptor's status word so that the host can reclaim the buffer.

The memory port is word-wide and has a fixed read latency of one cycle: read data for an access issued in one cycle is presented in the next. The outgoing byte stream uses valid/ready handshaking. A byte transfers only on a cycle where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the engine holds every stream output steady. The request input has no back-pressure. A write that arrives while the queue is full is discarded and recorded in a sticky flag. The queue occupancy, the overflow flag and a count of completed frames are plain status outputs.

Top module: `txd_engine`

## Requirements
- R1: A request word holds the descriptor byte offset in bits 23:0 and the total descriptor length, in units of 8 bytes, in bits 31:24. Offset bits 1:0 are ignored, so the first memory access for a request is a read at the offset with bits 1:0 cleared.
- R2: Requests are served one at a time, strictly in the order they were accepted. Serving a request begins with a read of the first header word, and `tx_valid` is high only while payload bytes are being offered.
- R3: The queue holds 64 requests. A write that arrives while it is full is dropped and sets `overflow`. `overflow` stays set until reset.
- R4: The first header word carries the payload length in bits 15:0. The number of bytes sent is the smaller of that length and 8*L-16, where L is the request's length field. The count is zero when L is below 2, so at most 2024 bytes are sent.
- R5: Payload bytes start at offset+16 and go out in ascending address order, least significant byte of each memory word first. `tx_last` is high with the final byte.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_port` do not change, and no byte is skipped.
- R7: During a frame, `tx_port` equals bits 17:16 of the first header word: bit 16 selects port 0 and bit 17 selects port 1.
- R8: After the final byte, or directly after the header read when the byte count is zero, the engine issues exactly one single-cycle write of 32'h1 to offset+4.
- R9: `frame_count` increments by one for each completion write. `cnt_clear` sets it to zero and takes priority over an increment in the same cycle.
- R10: `fifo_flush` empties the queue. `fifo_level` reads zero in the next cycle. A request write in the same cycle is discarded without setting `overflow`. A frame already in progress still completes.
- R11: `fifo_level` equals the number of accepted requests not yet taken by the engine. After reset, `fifo_level`, `overflow`, `frame_count` and `tx_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| submit_wr | input | 1 | Request write strobe |
| submit_word | input | 32 | Request word: length units in bits 31:24, offset in bits 23:0 |
| fifo_flush | input | 1 | Discard all queued requests |
| cnt_clear | input | 1 | Zero the frame counter |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 24 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| tx_valid | output | 1 | Byte offered on the stream |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Payload byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_port | output | 2 | Port mask for the current frame |
| fifo_level | output | 7 | Queued requests |
| overflow | output | 1 | Sticky: a request was dropped because the queue was full |
| frame_count | output | 32 | Completed frames |

## Verification
The hardest state to reach from the ports is a full queue at the moment a flush and a new request arrive together. Requests are normally drained as fast as they are written. The bench therefore starts a 2024-byte frame and holds `tx_ready` low, which parks the engine mid-frame. It then writes 65 requests, so the last one meets a full queue, and follows with a flush that coincides with one more request write. Back-pressure and truncation cases are covered by frames whose header length is larger than the request's length field allows, by frames that reduce to zero bytes, and by `tx_ready` driven from a pseudo-random sequence.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int OFF_W     = 24;
  localparam int UNIT_W    = 8;
  localparam int HDR_BYTES = 16;
  localparam int BYTE_W    = UNIT_W + 3;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_LOAD, S_SEND, S_DONE
  } seq_state_t;

  typedef struct packed {
    logic [UNIT_W-1:0] units;
    logic [OFF_W-1:0]  off;
  } tx_req_t;
endpackage

// File: rtl/txd_req_fifo.sv
module txd_req_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          flush,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          avail,
  output logic [LW-1:0] level,
  output logic          ovf
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign avail   = (level != '0) && !flush;
  assign push_ok = push && !flush && !full;
  assign pop_ok  = pop && avail;
  assign dout    = store[rp];

  always_ff @(posedge clk) begin
    if (push_ok) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0; ovf <= 1'b0;
    end else if (flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      if (push && full) ovf <= 1'b1;
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/txd_frame_seq.sv
module txd_frame_seq
  import txd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_avail,
  input  tx_req_t          req,
  output logic             pop,
  output logic             mem_en,
  output logic             mem_we,
  output logic [OFF_W-1:0] mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic [1:0]       tx_port,
  output logic             done
);
  seq_state_t        st, st_n;
  logic [OFF_W-1:0]  base;
  logic [BYTE_W-1:0] lim, cnt, idx, idx_nx, n_sel;
  logic [31:0]       word;
  logic [1:0]        port;
  logic [15:0]       hdr_len;
  logic              at_last;

  assign idx_nx   = idx + 1'b1;
  assign hdr_len  = mem_rdata[15:0];
  assign n_sel    = (hdr_len < 16'(lim)) ? hdr_len[BYTE_W-1:0] : lim;
  assign at_last  = (idx == cnt - 1'b1);
  assign tx_valid = (st == S_SEND);
  assign tx_data  = word[{idx[1:0], 3'b000} +: 8];
  assign tx_last  = tx_valid && at_last;
  assign tx_port  = tx_valid ? port : 2'b00;

  always_comb begin
    st_n = st; pop = 1'b0; done = 1'b0;
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    case (st)
      S_IDLE: if (req_avail) begin
        pop = 1'b1; mem_en = 1'b1;
        mem_addr = req.off & ~OFF_W'(3);
        st_n = S_HDR;
      end
      S_HDR: if (n_sel == '0) st_n = S_DONE;
        else begin
          mem_en = 1'b1;
          mem_addr = base + OFF_W'(HDR_BYTES);
          st_n = S_LOAD;
        end
      S_LOAD: st_n = S_SEND;
      S_SEND: if (tx_ready) begin
        if (at_last) st_n = S_DONE;
        else if (idx[1:0] == 2'd3) begin
          mem_en = 1'b1;
          mem_addr = base + OFF_W'(HDR_BYTES) + OFF_W'({idx_nx[BYTE_W-1:2], 2'b00});
          st_n = S_LOAD;
        end
      end
      S_DONE: begin
        mem_en = 1'b1; mem_we = 1'b1; done = 1'b1;
        mem_addr = base + OFF_W'(4);
        mem_wdata = 32'h1;
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; lim <= '0; cnt <= '0; idx <= '0;
      word <= '0; port <= '0;
    end else begin
      st <= st_n;
      if (pop) begin
        base <= req.off & ~OFF_W'(3);
        lim  <= (req.units < UNIT_W'(2)) ? '0
              : {req.units, 3'b000} - BYTE_W'(HDR_BYTES);
      end
      if (st == S_HDR) begin
        cnt <= n_sel; port <= mem_rdata[17:16]; idx <= '0;
      end
      if (st == S_LOAD) word <= mem_rdata;
      if (st == S_SEND && tx_ready) idx <= idx_nx;
    end
  end
endmodule

// File: rtl/txd_frame_cnt.sv
module txd_frame_cnt #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clear,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (inc)        count <= count + 1'b1;
  end
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             submit_wr,
  input  logic [31:0]      submit_word,
  input  logic             fifo_flush,
  input  logic             cnt_clear,
  output logic             mem_en,
  output logic             mem_we,
  output logic [OFF_W-1:0] mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic [1:0]       tx_port,
  output logic [LVL_W-1:0] fifo_level,
  output logic             overflow,
  output logic [CNT_W-1:0] frame_count
);
  tx_req_t head;
  logic    avail, pop, done;

  txd_req_fifo #(.DEPTH(DEPTH), .W($bits(tx_req_t))) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(submit_wr), .din(submit_word),
    .flush(fifo_flush), .pop(pop), .dout(head), .avail(avail),
    .level(fifo_level), .ovf(overflow)
  );

  txd_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_avail(avail), .req(head), .pop(pop),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_port(tx_port), .done(done)
  );

  txd_frame_cnt #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(done), .clear(cnt_clear),
    .count(frame_count)
  );
endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk #(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_flush,
  input logic             cnt_clear,
  input logic             mem_we,
  input logic [31:0]      mem_wdata,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic [1:0]       tx_port,
  input logic [LVL_W-1:0] fifo_level,
  input logic             overflow,
  input logic [CNT_W-1:0] frame_count
);
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_port));

  a_r5_last_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r3_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> fifo_level == '0);

  a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r8_flag_value: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata == 32'h1);

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> (frame_count == $past(frame_count)) || (frame_count == $past(frame_count) + 1'b1));

  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> frame_count == '0);
endmodule

bind txd_engine txd_engine_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_txd_engine.sv
module test_txd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        submit_wr = 1'b0;
  logic [31:0] submit_word = '0;
  logic        fifo_flush = 1'b0;
  logic        cnt_clear = 1'b0;
  logic        mem_en, mem_we;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic [1:0]  tx_port;
  logic [6:0]  fifo_level;
  logic        overflow;
  logic [31:0] frame_count;

  always #5 clk = ~clk;

  txd_engine i_txd_engine (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [0:1023];
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int ms = 0, mbase = 0, mlim = 0, mcnt = 0, midx = 0, mport = 0;
  int q[$];
  bit movf = 0;
  longint mcount = 0;
  int dut_bytes = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int hdr_count(int base, int lim);
    int h = int'(mem[(base >> 2) & 1023] & 32'hFFFF);
    return (h < lim) ? h : lim;
  endfunction

  function automatic int pay_byte(int base, int i);
    logic [31:0] w = mem[((base + 16 + (i & ~3)) >> 2) & 1023];
    return int'(w[8*(i%4) +: 8]);
  endfunction

  // memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  // stream sink ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= (ready_mode == 0) ? 1'b0 : (ready_mode == 1) ? 1'b1 : lfsr[0];
  end

  // reference model update
  always @(posedge clk) begin
    int sz, r, u, n;
    cyc++;
    if (!rst_n) begin
      ms = 0; q.delete(); movf = 0; mcount = 0; dut_bytes = 0;
    end else begin
      if (tx_valid && tx_ready) dut_bytes++;
      sz = q.size();
      if (ms == 4) begin
        chk(dut_bytes == mcnt, "R4", dut_bytes, mcnt);
        dut_bytes = 0;
      end
      if (cnt_clear) mcount = 0;
      else if (ms == 4) mcount++;
      case (ms)
        0: if (sz > 0 && !fifo_flush) begin
             r = q.pop_front();
             mbase = (r & 32'hFFFFFF) & ~3;
             u = (r >> 24) & 255;
             mlim = (u < 2) ? 0 : u*8 - 16;
             ms = 1;
           end
        1: begin
             n = hdr_count(mbase, mlim);
             mport = int'((mem[(mbase >> 2) & 1023] >> 16) & 3);
             mcnt = n; midx = 0;
             ms = (n == 0) ? 4 : 2;
           end
        2: ms = 3;
        3: if (tx_ready) begin
             if (midx == mcnt - 1) ms = 4;
             else begin
               if (midx % 4 == 3) ms = 2;
               midx++;
             end
           end
        4: ms = 0;
        default: ms = 0;
      endcase
      if (fifo_flush) q.delete();
      else if (submit_wr) begin
        if (sz == 64) movf = 1;
        else q.push_back(int'(submit_word));
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit e_en, e_we;
    int e_addr;
    #3;
    if (rst_n) begin
      chk(tx_valid == (ms == 3), "R2", tx_valid, ms == 3);
      if (ms == 3 && tx_valid) begin
        chk(tx_data == pay_byte(mbase, midx), tx_ready ? "R5" : "R6",
            tx_data, pay_byte(mbase, midx));
        chk(tx_last == (midx == mcnt - 1), "R5", tx_last, midx == mcnt - 1);
        chk(tx_port == mport, "R7", tx_port, mport);
      end
      e_en = 0; e_we = 0; e_addr = 0;
      case (ms)
        0: begin e_en = q.size() > 0 && !fifo_flush;
                 if (e_en) e_addr = (q[0] & 32'hFFFFFF) & ~3; end
        1: begin e_en = hdr_count(mbase, mlim) != 0; e_addr = mbase + 16; end
        3: begin e_en = tx_ready && midx != mcnt - 1 && midx % 4 == 3;
                 e_addr = mbase + 16 + midx + 1; end
        4: begin e_en = 1; e_we = 1; e_addr = mbase + 4; end
        default: ;
      endcase
      chk(mem_en == e_en, "R2", mem_en, e_en);
      if (e_en && mem_en) begin
        chk(mem_we == e_we, "R8", mem_we, e_we);
        chk(mem_addr == 24'(e_addr), "R1", mem_addr, e_addr);
        if (e_we) chk(mem_wdata == 32'h1, "R8", mem_wdata, 1);
      end
      chk(fifo_level == q.size(), "R11", fifo_level, q.size());
      chk(overflow == movf, "R3", overflow, movf);
      chk(frame_count == mcount, "R9", frame_count, mcount);
    end
  end

  task automatic submit(int off, int units);
    @(negedge clk);
    submit_wr = 1'b1; submit_word = {8'(units), 24'(off)};
    @(negedge clk);
    submit_wr = 1'b0;
  endtask

  task automatic wait_drained();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (ms == 0 && q.size() == 0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic put_desc(int off, int len, int portbyte);
    mem[off >> 2] = {8'h5A, 8'(portbyte), 16'(len)};
    mem[(off >> 2) + 1] = 32'h0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h0F1E2D3C;
    put_desc(12'h000, 5,    8'hFD);  // port mask 01, upper bits ignored
    put_desc(12'h100, 12,   8'h02);
    put_desc(12'h200, 20,   8'h03);
    put_desc(12'h300, 0,    8'h01);
    put_desc(12'h800, 2024, 8'h01);
    repeat (3) @(negedge clk);
    #4;
    // R11: reset values
    chk(fifo_level == 0, "R11", fifo_level, 0);
    chk(overflow == 0, "R11", overflow, 0);
    chk(frame_count == 0, "R11", frame_count, 0);
    chk(tx_valid == 0, "R11", tx_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    ready_mode = 2;
    submit(12'h000, 3);    // R4: 5 bytes within limit 8
    submit(12'h100, 2);    // R4: limit zero
    submit(12'h200, 4);    // R4: truncated to 16
    submit(12'h300, 2);    // zero-length header
    submit(12'h802, 255);  // R1: offset bits 1:0 ignored, 2024 bytes
    wait_drained();
    chk(mem[1] == 1, "R8", mem[1], 1);
    chk(mem[(12'h100 >> 2) + 1] == 1, "R8", mem[(12'h100 >> 2) + 1], 1);
    chk(mem[(12'h200 >> 2) + 1] == 1, "R8", mem[(12'h200 >> 2) + 1], 1);
    chk(mem[(12'h300 >> 2) + 1] == 1, "R8", mem[(12'h300 >> 2) + 1], 1);
    chk(mem[(12'h800 >> 2) + 1] == 1, "R8", mem[(12'h800 >> 2) + 1], 1);
    chk(frame_count == 5, "R9", frame_count, 5);
    @(negedge clk); cnt_clear = 1'b1;
    @(negedge clk); cnt_clear = 1'b0; #4;
    chk(frame_count == 0, "R9", frame_count, 0);
    // R3/R10: park engine mid-frame, fill queue, overflow, flush
    ready_mode = 0;
    submit(12'h800, 255);
    repeat (6) @(negedge clk);
    for (int k = 0; k < 65; k++) submit(12'h000, 3);
    #4;
    chk(fifo_level == 64, "R3", fifo_level, 64);
    chk(overflow == 1, "R3", overflow, 1);
    @(negedge clk);
    fifo_flush = 1'b1; submit_wr = 1'b1; submit_word = {8'd2, 24'h300};
    @(negedge clk);
    fifo_flush = 1'b0; submit_wr = 1'b0; #4;
    chk(fifo_level == 0, "R10", fifo_level, 0);
    chk(overflow == 1, "R10", overflow, 1);
    submit(12'h300, 2);
    submit(12'h000, 3);
    ready_mode = 2;
    wait_drained();
    chk(frame_count == 3, "R10", frame_count, 3);
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end
endmodule